// File: doc/BRIEF.md
# DRAM Direct Command Issue Register

This block is a 32-bit software-writable control word that lets firmware put single, raw commands on a DDR3 command/address bus while memory is being brought up. Typical uses are mode-register programming, opening or closing a row, a lone read or write CAS, and configuration writes to the register buffer of a registered module. Software writes one word that holds a command-kind flag, a destination rank, bank bits and address bits. One clock later the block drives exactly one command cycle: the per-rank chip selects, the RAS#/CAS#/WE# triple, BA and MA, together with a one-cycle command strobe.

No DRAM timing is enforced. Every accepted write can issue a command, including writes on consecutive clocks. The write strobe is accepted on every cycle, so there is no back-pressure. The command outputs are a plain strobe with no ready, and the consumer must take each command in the cycle it appears. Once the initialization-done input is high, writes still update the stored word but never cause a command. Some flags clear themselves when their command goes out and others stay set, and the readback port shows which ones remain.

Top module: `dram_cmd_issue`

## Requirements
- R1: After reset the readback word is 0. The outputs are idle: cmd_valid=0, every chip select high, rc_cs_n=1, {ras_n,cas_n,we_n}=111, ba=0 and ma=0.
- R2: The stored word layout is as follows. Bit 28 = precharge flag, bit 27 = activate flag, bit 26 = register-buffer write flag, bit 25 = write flag, bit 24 = read flag, bit 23 = mode-register flag, bits 22:20 = rank, bits 19:16 = bank field, bits 15:0 = address. Bits 31:29 always read 0. Readback shows the stored value, including any hardware clearing.
- R3: A write that issues a command produces cmd_valid=1 with valid pins in the cycle after the write edge, for exactly one cycle. In every cycle without a command the outputs return to the idle values of R1.
- R4: {ras_n,cas_n,we_n} encodings: mode-register 000, precharge 010, activate 011, write 100, read 101, idle 111. A register-buffer write drives 000 with rc_cs_n low and all rank chip selects high.
- R5: The flags are ranked from highest to lowest as precharge, activate, register-buffer write, write, read, mode-register. Only the highest set flag is issued per write.
- R6: The issued flag is cleared in the stored word if it is mode-register, read, write or register-buffer write. Precharge and activate stay set, and no other flag is altered.
- R7: For rank commands, cs_n[rank] is low and every other chip select is high.
- R8: ba carries bits 18:16 of the written word and ma carries bits 15:0.
- R9: While init_done is high, a write updates the stored word without clearing any flag and issues no command.
- R10: When rdimm_en is low, the register-buffer write flag is ignored: it is stored, not issued, not cleared, and the next lower set flag is issued instead.
- R11: Writes on consecutive cycles each issue their own command on consecutive cycles.
- R12: A stored precharge or activate flag that is not rewritten causes no further command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Write strobe for the command word |
| reg_wr_data | input | 32 | Command word being written |
| reg_rd_data | output | 32 | Stored command word |
| init_done | input | 1 | Initialization complete; blocks all issue |
| rdimm_en | input | 1 | Registered modules supported |
| cmd_valid | output | 1 | One-cycle command strobe |
| cs_n | output | NUM_RANKS | Active-low rank chip selects |
| rc_cs_n | output | 1 | Active-low register-buffer chip select |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 3 | Bank address |
| ma | output | 16 | Memory address |

## Verification
The assertions assume that reset is held for at least one clock and that init_done and rdimm_en change only between clock edges. They also assume the rank field never points past NUM_RANKS, which holds at the default of eight ranks because every 3-bit rank value is then in range. The stimulus drives all inputs on the falling edge. It sweeps every flag combination with both settings of rdimm_en, derives the rank, bank and address fields from the sweep index so that they also cover their full ranges, and then raises init_done only after reset has completed.

// File: rtl/dram_cmd_pkg.sv
package dram_cmd_pkg;
  localparam int WORD_W   = 32;
  localparam int MA_W     = 16;
  localparam int BA_W     = 3;
  localparam int RANK_W   = 3;
  localparam int RANK_LSB = 20;
  localparam int BA_LSB   = 16;
  localparam int FLAG_LSB = 23;
  localparam int N_KINDS  = 6;

  // kind index k maps to word bit FLAG_LSB+k; larger index = higher priority
  typedef enum int {
    K_MRS = 0, K_RD = 1, K_WR = 2, K_RBW = 3, K_ACT = 4, K_PRE = 5
  } cmd_kind_e;

  localparam logic [N_KINDS-1:0] SELF_CLR = 6'b001111;
  localparam logic [WORD_W-1:0]  IMPL_MASK = 32'h1FFF_FFFF;

  typedef enum logic [2:0] {
    CODE_MRS = 3'b000,
    CODE_PRE = 3'b010,
    CODE_ACT = 3'b011,
    CODE_WR  = 3'b100,
    CODE_RD  = 3'b101,
    CODE_NOP = 3'b111
  } cmd_code_e;

  function automatic cmd_code_e kind_code(input int k);
    case (k)
      K_MRS:   return CODE_MRS;
      K_RD:    return CODE_RD;
      K_WR:    return CODE_WR;
      K_RBW:   return CODE_MRS;
      K_ACT:   return CODE_ACT;
      K_PRE:   return CODE_PRE;
      default: return CODE_NOP;
    endcase
  endfunction
endpackage

// File: rtl/cmd_word_reg.sv
module cmd_word_reg
  import dram_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [N_KINDS-1:0] clr_kinds,
  output logic [WORD_W-1:0] q
);
  logic [WORD_W-1:0] clr_bits;

  always_comb begin
    clr_bits = '0;
    clr_bits[FLAG_LSB +: N_KINDS] = clr_kinds;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      q <= '0;
    else if (wr_en)
      q <= wr_data & IMPL_MASK & ~clr_bits;
  end
endmodule

// File: rtl/cmd_priority_sel.sv
module cmd_priority_sel
  import dram_cmd_pkg::*;
(
  input  logic [N_KINDS-1:0] flags,
  input  logic               enable,
  input  logic               rdimm_en,
  output logic [N_KINDS-1:0] grant,
  output logic               any
);
  logic [N_KINDS-1:0] honoured;

  always_comb begin
    honoured = flags;
    honoured[K_RBW] = flags[K_RBW] & rdimm_en;
    if (!enable) honoured = '0;
  end

  always_comb begin
    grant = '0;
    for (int k = 0; k < N_KINDS; k++) begin
      if (honoured[k]) begin
        grant    = '0;
        grant[k] = 1'b1;
      end
    end
  end

  assign any = |honoured;
endmodule

// File: rtl/rank_cs_decode.sv
module rank_cs_decode #(
  parameter int NUM_RANKS = 8,
  parameter int SEL_W     = 3
) (
  input  logic [SEL_W-1:0]     rank,
  input  logic                 en,
  output logic [NUM_RANKS-1:0] cs_n
);
  for (genvar i = 0; i < NUM_RANKS; i++) begin : g_rank
    assign cs_n[i] = !(en && (32'(rank) == i));
  end
endmodule

// File: rtl/dram_cmd_issue.sv
module dram_cmd_issue
  import dram_cmd_pkg::*;
#(
  parameter int NUM_RANKS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic [31:0]          reg_wr_data,
  output logic [31:0]          reg_rd_data,
  input  logic                 init_done,
  input  logic                 rdimm_en,
  output logic                 cmd_valid,
  output logic [NUM_RANKS-1:0] cs_n,
  output logic                 rc_cs_n,
  output logic                 ras_n,
  output logic                 cas_n,
  output logic                 we_n,
  output logic [2:0]           ba,
  output logic [15:0]          ma
);
  localparam logic [NUM_RANKS-1:0] CS_IDLE = '1;

  logic [N_KINDS-1:0]   grant;
  logic                 issue;
  logic                 is_rbw;
  logic [NUM_RANKS-1:0] cs_dec_n;
  cmd_code_e            code;

  cmd_priority_sel u_sel (
    .flags    (reg_wr_data[FLAG_LSB +: N_KINDS]),
    .enable   (reg_wr_en & ~init_done),
    .rdimm_en (rdimm_en),
    .grant    (grant),
    .any      (issue)
  );

  cmd_word_reg u_word (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .wr_data   (reg_wr_data),
    .clr_kinds (grant & SELF_CLR),
    .q         (reg_rd_data)
  );

  assign is_rbw = grant[K_RBW];

  rank_cs_decode #(.NUM_RANKS(NUM_RANKS), .SEL_W(RANK_W)) u_cs (
    .rank (reg_wr_data[RANK_LSB +: RANK_W]),
    .en   (issue & ~is_rbw),
    .cs_n (cs_dec_n)
  );

  always_comb begin
    code = CODE_NOP;
    for (int k = 0; k < N_KINDS; k++)
      if (grant[k]) code = kind_code(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !issue) begin
      cmd_valid             <= 1'b0;
      cs_n                  <= CS_IDLE;
      rc_cs_n               <= 1'b1;
      {ras_n, cas_n, we_n}  <= CODE_NOP;
      ba                    <= '0;
      ma                    <= '0;
    end else begin
      cmd_valid             <= 1'b1;
      cs_n                  <= cs_dec_n;
      rc_cs_n               <= ~is_rbw;
      {ras_n, cas_n, we_n}  <= code;
      ba                    <= reg_wr_data[BA_LSB +: BA_W];
      ma                    <= reg_wr_data[MA_W-1:0];
    end
  end
endmodule

// File: rtl/dram_cmd_issue_chk.sv
module dram_cmd_issue_chk #(
  parameter int NUM_RANKS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr_en,
  input logic                 init_done,
  input logic                 rdimm_en,
  input logic                 cmd_valid,
  input logic [NUM_RANKS-1:0] cs_n,
  input logic                 rc_cs_n,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n
);
  assert_issue_follows_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(reg_wr_en));

  assert_idle_pins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> (&cs_n && rc_cs_n && {ras_n, cas_n, we_n} == 3'b111));

  assert_no_nop_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> {ras_n, cas_n, we_n} != 3'b111);

  assert_rank_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_one_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($countones(~cs_n) + (rc_cs_n ? 0 : 1)) == 1);

  assert_init_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !$past(init_done));

  assert_rbw_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rc_cs_n |-> ($past(rdimm_en) && {ras_n, cas_n, we_n} == 3'b000));
endmodule

bind dram_cmd_issue dram_cmd_issue_chk #(.NUM_RANKS(NUM_RANKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .init_done (init_done),
  .rdimm_en  (rdimm_en),
  .cmd_valid (cmd_valid),
  .cs_n      (cs_n),
  .rc_cs_n   (rc_cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n)
);

// File: tb/test_dram_cmd_issue.sv
module test_dram_cmd_issue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic        init_done = 1'b0;
  logic        rdimm_en = 1'b0;
  logic        cmd_valid;
  logic [7:0]  cs_n;
  logic        rc_cs_n, ras_n, cas_n, we_n;
  logic [2:0]  ba;
  logic [15:0] ma;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dram_cmd_issue #(.NUM_RANKS(8)) i_dram_cmd_issue (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .init_done(init_done), .rdimm_en(rdimm_en),
    .cmd_valid(cmd_valid), .cs_n(cs_n), .rc_cs_n(rc_cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .ma(ma)
  );

  localparam logic [31:0] IDLE_PINS = {1'b0, 1'b1, 8'hFF, 3'b111, 3'b000, 16'h0000};

  function automatic int pick(logic [31:0] d, logic re, logic idn);
    int k = -1;
    if (!idn)
      for (int j = 0; j < 6; j++)
        if (d[23+j] && !(j == 3 && !re)) k = j;
    return k;
  endfunction

  function automatic logic [31:0] exp_pins(logic [31:0] d, logic re, logic idn);
    int k = pick(d, re, idn);
    logic [2:0] c;
    logic [7:0] cs;
    if (k < 0) return IDLE_PINS;
    case (k)
      0: c = 3'b000; 1: c = 3'b101; 2: c = 3'b100;
      3: c = 3'b000; 4: c = 3'b011; default: c = 3'b010;
    endcase
    cs = (k == 3) ? 8'hFF : ~(8'b1 << d[22:20]);
    return {1'b1, (k == 3) ? 1'b0 : 1'b1, cs, c, d[18:16], d[15:0]};
  endfunction

  function automatic logic [31:0] exp_rb(logic [31:0] d, logic re, logic idn);
    int k = pick(d, re, idn);
    logic [31:0] r = d & 32'h1FFF_FFFF;
    if (k >= 0 && k <= 3) r[23+k] = 1'b0;
    return r;
  endfunction

  function automatic logic [31:0] pins();
    return {cmd_valid, rc_cs_n, cs_n, ras_n, cas_n, we_n, ba, ma};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pins", pins(), IDLE_PINS);
    check("R1 readback", reg_rd_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pins after release", pins(), IDLE_PINS);

    // R2 layout: all ones, precharge wins and stays set
    wr(32'hFFFF_FFFF);
    check("R2 readback unused bits zero", reg_rd_data, 32'h1FFF_FFFF);
    check("R5 precharge wins", pins(), exp_pins(32'hFFFF_FFFF, 1'b0, 1'b0));

    // Sweep every flag set against both rdimm_en values: R3 R4 R5 R6 R7 R8 R10
    for (int re = 0; re < 2; re++) begin
      for (int f = 0; f < 64; f++) begin
        d = {3'b000, 6'(f), 3'(f + re), 4'(f * 3), 16'(f * 1031 + re * 7)};
        rdimm_en = re[0];
        wr(d);
        check("R3/R4/R5/R7/R8/R10 pins", pins(), exp_pins(d, re[0], 1'b0));
        check("R6/R10 readback", reg_rd_data, exp_rb(d, re[0], 1'b0));
        @(negedge clk);
        check("R3/R12 idle after strobe", pins(), IDLE_PINS);
      end
    end

    // R11 back-to-back writes
    rdimm_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_wr_data = 32'h0180_1234;
    @(negedge clk);
    check("R11 first pins", pins(), exp_pins(32'h0180_1234, 1'b1, 1'b0));
    reg_wr_data = 32'h0235_ABCD;
    @(negedge clk);
    reg_wr_en = 1'b0;
    check("R11 second pins", pins(), exp_pins(32'h0235_ABCD, 1'b1, 1'b0));
    check("R11 second readback", reg_rd_data, exp_rb(32'h0235_ABCD, 1'b1, 1'b0));

    // R12 sticky activate: no reissue across idle cycles
    wr(32'h0850_0042);
    check("R12 activate issued", pins(), exp_pins(32'h0850_0042, 1'b1, 1'b0));
    repeat (3) @(negedge clk);
    check("R12 no reissue", pins(), IDLE_PINS);
    check("R12 flag kept", reg_rd_data, 32'h0850_0042);

    // R9 init_done blocks issue, word still updated without clearing
    init_done = 1'b1;
    for (int f = 0; f < 64; f += 9) begin
      d = {3'b000, 6'(f), 3'(f), 4'(f), 16'(f * 77)};
      wr(d);
      check("R9 no command", pins(), IDLE_PINS);
      check("R9 readback", reg_rd_data, d);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule